// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block is a small two-level AND-OR array whose connections come from a serially loaded configuration. Four data inputs are each offered to the AND plane in true and inverted form. Each product line is the AND of the literals connected to it. Each output is the OR of the product lines connected to it. The result is purely combinational from the data inputs and the active configuration.

The configuration is shifted in one bit per clock into a shadow register. A commit strobe copies the shadow and the mode selector into the active configuration. The mode picks one of three plane structures. In the fully programmable mode both planes come from configuration bits. In the fixed-OR mode the AND plane is programmable and each output ORs a hard-wired group of product lines. In the decoder mode the AND plane is a fixed full decoder of all 16 input codes, and only the OR plane is programmable. Until the first commit, all outputs are held at 0.

Top module: `sop_logic_array`

## Requirements
- R1: After reset (`rstN` low), `dataOut` is 0 and `cfgValid` is 0.
- R2: Each clock with `cfgEn` high shifts `cfgData` into bit 0 of a 112-bit shadow register, and the older bits move up by one. The bit shifted first therefore ends at bit 111 after 112 shifts. Bits 0..63 hold the AND plane: bit 8*p+2*i connects input i in true form to product p, and bit 8*p+2*i+1 connects it in inverted form. Bits 64..111 hold the OR plane: bit 64+16*o+t connects term t to output o.
- R3: On a clock with `cfgCommit` high, the shadow register and `modeSel` are copied into the active configuration. `cfgValid` is 1 from the next cycle and stays 1 until reset.
- R4: While `cfgValid` is 0, `dataOut` is 0 for every input.
- R5: Shifting without a commit leaves the outputs unchanged; they still follow the previously committed configuration.
- R6: With mode code 0 or 3 (fully programmable), product p (0..7) is the AND of its connected literals. Output o is the OR of the products p whose OR bit is set. OR bits for terms 8..15 have no effect.
- R7: A product line with no connected literals is 1. An output with no connected product lines is 0.
- R8: With mode code 1 (fixed OR), output o is the OR of products p with p/3 == o: products 0-2 feed output 0, 3-5 feed output 1, 6-7 feed output 2. All OR configuration bits have no effect.
- R9: With mode code 2 (decoder), output o equals OR bit 64+16*o+x, where x is the value of `dataIn`. The AND configuration bits have no effect.
- R10: When `cfgEn` and `cfgCommit` are high in the same cycle, the commit takes the shadow contents from before that clock edge. The bit shifted in that cycle lands only in the shadow register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgEn | input | 1 | Shift one configuration bit this cycle |
| cfgData | input | 1 | Serial configuration bit |
| cfgCommit | input | 1 | Copy the shadow configuration and mode into the active configuration |
| modeSel | input | 2 | Plane mode: 0/3 fully programmable, 1 fixed OR, 2 decoder |
| dataIn | input | 4 | Array inputs |
| dataOut | output | 3 | Sum-of-products outputs |
| cfgValid | output | 1 | Set by the first commit |

## Verification
A shift and a commit can fall in the same clock. That clock must both push a new bit into the shadow and copy the shadow into the active configuration. To provoke it, the bench loads a complete vector without committing, then raises `cfgEn` and `cfgCommit` together. It then sweeps all 16 input codes against the model of the unshifted vector. A following commit alone must make the outputs match the model of the vector shifted by one bit, with the new bit at position 0.

// File: rtl/sop_array_pkg.sv
package sop_array_pkg;

  typedef enum logic [1:0] {
    MODE_FULL = 2'd0,
    MODE_FIXOR = 2'd1,
    MODE_DECODE = 2'd2,
    MODE_FULL_ALT = 2'd3
  } arrayMode_e;

  typedef struct packed {
    logic shift;
    logic load;
  } cfgStrobe_t;

endpackage

// File: rtl/sop_array_ctrl.sv
module sop_array_ctrl
  import sop_array_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgEn,
  input  logic       cfgCommit,
  output cfgStrobe_t strobe,
  output logic       cfgValid
);

  always_comb begin
    strobe.shift = cfgEn;
    strobe.load  = cfgCommit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgValid <= 1'b0;
    else if (cfgCommit) cfgValid <= 1'b1;
  end

  p_valid_after_commit_r3: assert property (@(posedge clk) disable iff (!rstN)
    cfgCommit |=> cfgValid);

  p_valid_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid |=> cfgValid);

endmodule

// File: rtl/sop_array_datapath.sv
module sop_array_datapath
  import sop_array_pkg::*;
#(
  parameter int NUM_IN   = 4,
  parameter int NUM_PROD = 8,
  parameter int NUM_OUT  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strobe,
  input  logic              cfgData,
  input  logic [1:0]        modeSel,
  input  logic              cfgValid,
  input  logic [NUM_IN-1:0] dataIn,
  output logic [NUM_OUT-1:0] dataOut
);

  localparam int LIT       = 2 * NUM_IN;
  localparam int ROM_TERMS = 1 << NUM_IN;
  localparam int TERMS     = (NUM_PROD > ROM_TERMS) ? NUM_PROD : ROM_TERMS;
  localparam int AND_BITS  = NUM_PROD * LIT;
  localparam int OR_BITS   = NUM_OUT * TERMS;
  localparam int CFG_BITS  = AND_BITS + OR_BITS;
  localparam int GROUP     = (NUM_PROD + NUM_OUT - 1) / NUM_OUT;

  function automatic logic [TERMS-1:0] fixedMaskFor(input int outIdx);
    logic [TERMS-1:0] m;
    for (int t = 0; t < TERMS; t++) m[t] = (t < NUM_PROD) && ((t / GROUP) == outIdx);
    return m;
  endfunction

  logic [CFG_BITS-1:0] shadowQ;
  logic [CFG_BITS-1:0] activeQ;
  arrayMode_e          modeQ;
  logic [LIT-1:0]      literals;
  logic [NUM_PROD-1:0] progProd;
  logic [TERMS-1:0]    progWide;
  logic [TERMS-1:0]    decodeProd;
  logic [TERMS-1:0]    termLine;
  logic [NUM_OUT-1:0]  sumOut;

  // configuration storage: serial shadow and committed copy
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowQ <= '0;
      activeQ <= '0;
      modeQ   <= MODE_FULL;
    end else begin
      if (strobe.shift) shadowQ <= {shadowQ[CFG_BITS-2:0], cfgData};
      if (strobe.load) begin
        activeQ <= shadowQ;
        modeQ   <= arrayMode_e'(modeSel);
      end
    end
  end

  // dual-rail literals
  generate
    for (genvar i = 0; i < NUM_IN; i++) begin : g_lit
      assign literals[2*i]   = dataIn[i];
      assign literals[2*i+1] = ~dataIn[i];
    end
  endgenerate

  // programmable AND plane: an unconnected literal does not pull the product low
  generate
    for (genvar p = 0; p < NUM_PROD; p++) begin : g_prod
      assign progProd[p] = &(~activeQ[p*LIT +: LIT] | literals);
    end
  endgenerate

  assign progWide = TERMS'(progProd);

  // fixed full decoder plane
  generate
    for (genvar t = 0; t < TERMS; t++) begin : g_dec
      if (t < ROM_TERMS) begin : g_on
        localparam logic [NUM_IN-1:0] CODE = NUM_IN'(t);
        assign decodeProd[t] = (dataIn == CODE);
      end else begin : g_off
        assign decodeProd[t] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    if (modeQ == MODE_DECODE) termLine = decodeProd;
    else termLine = progWide;
  end

  // OR plane: configured or hard-wired grouping
  generate
    for (genvar o = 0; o < NUM_OUT; o++) begin : g_sum
      localparam logic [TERMS-1:0] FIX_MASK = fixedMaskFor(o);
      logic [TERMS-1:0] orMask;
      assign orMask = (modeQ == MODE_FIXOR) ? FIX_MASK : activeQ[AND_BITS + o*TERMS +: TERMS];
      assign sumOut[o] = |(termLine & orMask);
    end
  endgenerate

  assign dataOut = cfgValid ? sumOut : '0;

  p_shift_entry_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shift |=> shadowQ[0] == $past(cfgData));

  p_shadow_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.shift |=> $stable(shadowQ));

  p_commit_copy_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> activeQ == $past(shadowQ));

  p_active_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(activeQ) && $stable(modeQ));

  p_decode_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_DECODE) |-> $onehot0(termLine));

endmodule

// File: rtl/sop_logic_array.sv
module sop_logic_array
  import sop_array_pkg::*;
#(
  parameter int NUM_IN   = 4,
  parameter int NUM_PROD = 8,
  parameter int NUM_OUT  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgEn,
  input  logic               cfgData,
  input  logic               cfgCommit,
  input  logic [1:0]         modeSel,
  input  logic [NUM_IN-1:0]  dataIn,
  output logic [NUM_OUT-1:0] dataOut,
  output logic               cfgValid
);

  cfgStrobe_t strobe;

  sop_array_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgEn    (cfgEn),
    .cfgCommit(cfgCommit),
    .strobe   (strobe),
    .cfgValid (cfgValid)
  );

  sop_array_datapath #(
    .NUM_IN  (NUM_IN),
    .NUM_PROD(NUM_PROD),
    .NUM_OUT (NUM_OUT)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .cfgData (cfgData),
    .modeSel (modeSel),
    .cfgValid(cfgValid),
    .dataIn  (dataIn),
    .dataOut (dataOut)
  );

  p_quiet_unconfigured_r4: assert property (@(posedge clk) disable iff (!rstN)
    !cfgValid |-> dataOut == '0);

endmodule

// File: tb/sop_logic_array_tb.sv
module sop_logic_array_tb;

  localparam int CFG_BITS = 112;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgEn = 1'b0;
  logic       cfgData = 1'b0;
  logic       cfgCommit = 1'b0;
  logic [1:0] modeSel = 2'd0;
  logic [3:0] dataIn = 4'd0;
  logic [2:0] dataOut;
  logic       cfgValid;

  int  nChecks = 0;
  int  nFails = 0;
  bit  finished = 1'b0;
  logic [31:0] rngState = 32'h1234_5678;

  sop_logic_array u_dut (
    .clk(clk), .rstN(rstN), .cfgEn(cfgEn), .cfgData(cfgData), .cfgCommit(cfgCommit),
    .modeSel(modeSel), .dataIn(dataIn), .dataOut(dataOut), .cfgValid(cfgValid)
  );

  always #4 clk = ~clk;

  function automatic logic [31:0] nextRand(input logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  function automatic logic [2:0] model(input logic [CFG_BITS-1:0] v, input logic [1:0] m,
                                       input logic [3:0] x);
    logic [2:0] r = 3'b000;
    if (m == 2'd2) begin
      for (int o = 0; o < 3; o++) r[o] = v[64 + 16*o + int'(x)];
    end else begin
      for (int p = 0; p < 8; p++) begin
        logic prod = 1'b1;
        for (int i = 0; i < 4; i++) begin
          if (v[8*p + 2*i] && !x[i]) prod = 1'b0;
          if (v[8*p + 2*i + 1] && x[i]) prod = 1'b0;
        end
        if (m == 2'd1) begin
          if (prod) r[p/3] = 1'b1;
        end else begin
          for (int o = 0; o < 3; o++) if (prod && v[64 + 16*o + p]) r[o] = 1'b1;
        end
      end
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic makeVec(output logic [CFG_BITS-1:0] v);
    for (int k = 0; k < CFG_BITS; k++) begin
      logic a, b;
      rngState = nextRand(rngState);
      a = rngState[7];
      b = rngState[19];
      // sparse AND plane so products are not always contradictory; dense OR plane
      v[k] = (k < 64) ? (a & b) : a;
    end
  endtask

  task automatic shiftVec(input logic [CFG_BITS-1:0] v);
    for (int k = CFG_BITS - 1; k >= 0; k--) begin
      @(negedge clk);
      cfgEn = 1'b1;
      cfgData = v[k];
    end
    @(negedge clk);
    cfgEn = 1'b0;
  endtask

  task automatic commit(input logic [1:0] m);
    @(negedge clk);
    modeSel = m;
    cfgCommit = 1'b1;
    @(negedge clk);
    cfgCommit = 1'b0;
  endtask

  task automatic sweep(input string tag, input logic [CFG_BITS-1:0] v, input logic [1:0] m);
    for (int x = 0; x < 16; x++) begin
      dataIn = 4'(x);
      #1;
      check(tag, 32'(dataOut), 32'(model(v, m, 4'(x))));
    end
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [CFG_BITS-1:0] va, vb, vz;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset dataOut", 32'(dataOut), 0);
    check("R1 reset cfgValid", 32'(cfgValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    sweep("R4 unconfigured after reset", '0, 2'd0);

    // R4: loaded but not committed keeps outputs quiet
    makeVec(va);
    shiftVec(va);
    for (int x = 0; x < 16; x++) begin
      dataIn = 4'(x);
      #1;
      check("R4 uncommitted quiet", 32'(dataOut), 0);
    end
    check("R4 cfgValid still low", 32'(cfgValid), 0);

    // R3 + R2 + R6: commit in fully programmable mode
    commit(2'd0);
    check("R3 cfgValid after commit", 32'(cfgValid), 1);
    sweep("R6 R2 full mode", va, 2'd0);

    // several vectors across all modes
    for (int s = 0; s < 6; s++) begin
      makeVec(va);
      shiftVec(va);
      commit(2'd0); sweep("R6 full mode sweep", va, 2'd0);
      commit(2'd1); sweep("R8 fixed-or mode sweep", va, 2'd1);
      commit(2'd2); sweep("R9 decoder mode sweep", va, 2'd2);
      commit(2'd3); sweep("R6 alternate full code", va, 2'd3);
      check("R3 cfgValid sticky", 32'(cfgValid), 1);
    end

    // R7: empty AND plane makes every product 1; empty OR plane gives 0
    vz = '0;
    for (int k = 64; k < CFG_BITS; k++) vz[k] = 1'b1;
    shiftVec(vz);
    commit(2'd0);
    sweep("R7 empty products", vz, 2'd0);
    for (int x = 0; x < 16; x++) begin
      dataIn = 4'(x); #1;
      check("R7 empty products all ones", 32'(dataOut), 7);
    end
    commit(2'd1);
    for (int x = 0; x < 16; x++) begin
      dataIn = 4'(x); #1;
      check("R8 fixed groups all ones", 32'(dataOut), 7);
    end
    vz = '0;
    shiftVec(vz);
    commit(2'd0);
    for (int x = 0; x < 16; x++) begin
      dataIn = 4'(x); #1;
      check("R7 empty sums zero", 32'(dataOut), 0);
    end

    // R5: shifting a new vector does not disturb the committed one
    makeVec(va);
    shiftVec(va);
    commit(2'd0);
    makeVec(vb);
    shiftVec(vb);
    sweep("R5 old config holds during shift", va, 2'd0);
    commit(2'd0);
    sweep("R5 new config after commit", vb, 2'd0);

    // R10: shift and commit in the same cycle
    makeVec(va);
    shiftVec(va);
    @(negedge clk);
    cfgEn = 1'b1;
    cfgData = 1'b1;
    cfgCommit = 1'b1;
    modeSel = 2'd0;
    @(negedge clk);
    cfgEn = 1'b0;
    cfgCommit = 1'b0;
    sweep("R10 commit takes pre-edge shadow", va, 2'd0);
    vb = {va[CFG_BITS-2:0], 1'b1};
    commit(2'd0);
    sweep("R10 shifted bit lands in shadow", vb, 2'd0);
    commit(2'd2);
    sweep("R10 shifted shadow decoder", vb, 2'd2);

    // R1: reset again clears validity and outputs
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R1 reset mid-run dataOut", 32'(dataOut), 0);
    check("R1 reset mid-run cfgValid", 32'(cfgValid), 0);
    @(negedge clk);
    rstN = 1'b1;

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule